// File: doc/BRIEF.md
# Lock-Protected Command Mailbox

This block is a register-mapped mailbox that lets one requester pass a command word and a payload to a responder engine. The requester first claims the mailbox by reading the lock register: a read that returns zero makes it the owner. It then writes a command, a byte length and the payload words, and starts the job through the execute register. The engine pops the stored words in order, sees the command and length on dedicated pins, and posts a result flag and a 32-bit response word. The requester polls the status register and reads the response. Clearing the execute register then frees the mailbox.

A three-bit handshake state and a four-bit command status share one status register, next to a flag that shows the lock is held. Any write that breaks the expected order puts the mailbox into an error state whose command status reads failure. A write to the unlock register aborts everything from any state.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the status register (byte offset 0x1C) reads 0: the state field is idle, the command status is 0 and the lock flag is clear.
- R2: A read of the lock register (offset 0x00) returns 0 when the mailbox is free and grants the lock. Every later read returns 1 until the mailbox is released. While the lock is held, status bit 9 is 1.
- R3: Status bits [8:6] give the handshake state (0 idle, 1 awaiting command, 2 awaiting length, 3 awaiting data, 4 engine executing, 5 requester owns the result, 6 error). Bits [3:0] give the command status (0 busy, 1 data ready, 2 complete, 3 failure). All other bits read 0.
- R4: The state moves to 1 when the lock is granted. A write to the command register (0x08) moves it to 2, and a write to the length register (0x0C, a byte count) moves it to 3. Both values read back and appear on the engine's command and length outputs.
- R5: Each write to the data-in register (0x10) stores one word. The engine receives the words in write order, one per pop, and eng_avail drops after the last one.
- R6: Writing 1 to the execute register (0x18) once ceil(length/4) words are stored moves the state to 4 and signals eng_busy. The command status reads 0 (busy) until the engine posts.
- R7: An engine post moves the state to 5 and sets the command status to 2 (eng_fail low) or 3 (eng_fail high). The data-out register (0x14) then returns the posted response word.
- R8: Writing 0 to the execute register in state 5 or 6 returns the state to idle and frees the lock, so the next lock read returns 0.
- R9: While the lock is held, a command, length, data-in or execute write that does not fit the current state moves the state to 6 with command status 3.
- R10: A data-in write when ceil(length/4) words are already stored moves the state to 6 with command status 3.
- R11: Writing 1 to the execute register with fewer than ceil(length/4) words stored moves the state to 6 with command status 3.
- R12: A length larger than 4*DEPTH bytes (256 by default) moves the state to 6. A length of exactly 4*DEPTH is accepted.
- R13: A write to the unlock register (0x20) returns the mailbox to idle with the lock free, from any state.
- R14: While the lock is free, writes to the command, length, data-in and execute registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| eng_busy | output | 1 | A job is waiting for the engine (state 4) |
| eng_avail | output | 1 | An unread payload word is on eng_word |
| eng_word | output | 32 | Next payload word |
| eng_pop | input | 1 | Consume the word on eng_word |
| eng_cmd | output | 32 | Command word of the current job |
| eng_len | output | 32 | Byte length of the current job |
| eng_post | input | 1 | Engine finished the job |
| eng_fail | input | 1 | With eng_post: the job failed |
| eng_rsp | input | 32 | With eng_post: response word |

## Verification
A wrong handshake state shows up in the status register on the very next read, because bits [8:6] expose it directly. A state that has moved on too early also turns the next legal write into an error code 3, which shows one access later. A miscounted payload shows either as an error on the last data-in or execute write, or as a word out of order, or as a late eng_avail drop at the engine pins during the pops. A lock that is not released shows on the next lock read, which returns 1 where 0 is expected.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_LOCK   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_USER   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_DLEN   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_DIN    = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_DOUT   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_EXEC   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_UNLOCK = 6'h20;

    typedef enum logic [2:0] {
        FS_IDLE     = 3'd0,
        FS_CMD      = 3'd1,
        FS_LEN      = 3'd2,
        FS_DATA     = 3'd3,
        FS_EXEC_ENG = 3'd4,
        FS_EXEC_REQ = 3'd5,
        FS_ERR      = 3'd6
    } mbx_fsm_e;

    typedef enum logic [3:0] {
        CS_BUSY = 4'd0,
        CS_DRDY = 4'd1,
        CS_DONE = 4'd2,
        CS_FAIL = 4'd3
    } mbx_code_e;

endpackage

// File: rtl/mbx_buf.sv
module mbx_buf #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = IW + 1,
    localparam logic [31:0] CAP_BYTES = 32'(DEPTH * 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              buf_we,
    output logic [IW-1:0]     buf_widx,
    output logic [IW-1:0]     buf_ridx,
    output logic              eng_busy,
    output logic              eng_avail,
    input  logic              eng_pop,
    output logic [31:0]       eng_cmd,
    output logic [31:0]       eng_len,
    input  logic              eng_post,
    input  logic              eng_fail,
    input  logic [31:0]       eng_rsp
);

    typedef struct packed {
        mbx_fsm_e  fsm;
        logic      locked;
        mbx_code_e code;
        logic [31:0] cmd;
        logic [31:0] len;
        logic [CW-1:0] cnt;
        logic [CW-1:0] rptr;
        logic [31:0] rsp;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        fsm: FS_IDLE, locked: 1'b0, code: CS_BUSY,
        cmd: '0, len: '0, cnt: '0, rptr: '0, rsp: '0
    };

    ctrl_t st_d, st_q;
    logic  seq_bad;
    logic [31:0] need_w, cnt_w, rptr_w;

    assign need_w = (st_q.len + 32'd3) >> 2;
    assign cnt_w  = {{(32-CW){1'b0}}, st_q.cnt};
    assign rptr_w = {{(32-CW){1'b0}}, st_q.rptr};

    always_comb begin
        st_d      = st_q;
        seq_bad   = 1'b0;
        bus_rdata = '0;
        buf_we    = 1'b0;

        // engine side first, so a bus unlock in the same cycle wins
        if (st_q.fsm == FS_EXEC_ENG) begin
            if (eng_pop && (rptr_w < cnt_w)) begin
                st_d.rptr = st_q.rptr + 1'b1;
            end
            if (eng_post) begin
                st_d.fsm  = FS_EXEC_REQ;
                st_d.code = eng_fail ? CS_FAIL : CS_DONE;
                st_d.rsp  = eng_rsp;
            end
        end

        if (bus_rd) begin
            unique case (bus_addr)
                OFS_LOCK: begin
                    bus_rdata = {31'b0, st_q.locked};
                    if (!st_q.locked) begin
                        st_d.locked = 1'b1;
                        st_d.fsm    = FS_CMD;
                        st_d.code   = CS_BUSY;
                    end
                end
                OFS_CMD:  bus_rdata = st_q.cmd;
                OFS_DLEN: bus_rdata = st_q.len;
                OFS_DOUT: bus_rdata = st_q.rsp;
                OFS_STAT: bus_rdata = {22'b0, st_q.locked, st_q.fsm, 2'b00, st_q.code};
                default:  bus_rdata = '0;
            endcase
        end

        if (bus_wr) begin
            unique case (bus_addr)
                OFS_UNLOCK: st_d = CTRL_RST;
                OFS_CMD: if (st_q.locked) begin
                    if (st_q.fsm == FS_CMD) begin
                        st_d.cmd = bus_wdata;
                        st_d.fsm = FS_LEN;
                    end else seq_bad = 1'b1;
                end
                OFS_DLEN: if (st_q.locked) begin
                    if (st_q.fsm == FS_LEN && bus_wdata <= CAP_BYTES) begin
                        st_d.len  = bus_wdata;
                        st_d.cnt  = '0;
                        st_d.rptr = '0;
                        st_d.fsm  = FS_DATA;
                    end else seq_bad = 1'b1;
                end
                OFS_DIN: if (st_q.locked) begin
                    if (st_q.fsm == FS_DATA && cnt_w < need_w) begin
                        buf_we   = 1'b1;
                        st_d.cnt = st_q.cnt + 1'b1;
                    end else seq_bad = 1'b1;
                end
                OFS_EXEC: if (st_q.locked) begin
                    if (bus_wdata[0]) begin
                        if (st_q.fsm == FS_DATA && cnt_w == need_w) begin
                            st_d.fsm  = FS_EXEC_ENG;
                            st_d.code = CS_BUSY;
                        end else seq_bad = 1'b1;
                    end else if (st_q.fsm == FS_EXEC_REQ || st_q.fsm == FS_ERR) begin
                        st_d = CTRL_RST;
                    end else seq_bad = 1'b1;
                end
                default: ;
            endcase
        end

        if (seq_bad) begin
            st_d.fsm  = FS_ERR;
            st_d.code = CS_FAIL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTRL_RST;
        else        st_q <= st_d;
    end

    assign buf_widx  = st_q.cnt[IW-1:0];
    assign buf_ridx  = st_q.rptr[IW-1:0];
    assign eng_busy  = (st_q.fsm == FS_EXEC_ENG);
    assign eng_avail = eng_busy && (rptr_w < cnt_w);
    assign eng_cmd   = st_q.cmd;
    assign eng_len   = st_q.len;

    // R2: a read of a free lock grants it and opens the command stage
    p_lock_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == OFS_LOCK && !st_q.locked |=> st_q.locked && st_q.fsm == FS_CMD);

    // R6: engine stage holds busy until a post arrives
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fsm == FS_EXEC_ENG && !eng_post && !bus_wr |=> st_q.fsm == FS_EXEC_ENG && st_q.code == CS_BUSY);

    // R10: the stored word count never passes the declared length
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fsm == FS_DATA |-> cnt_w <= need_w);

    // R13: unlock always lands in idle with the lock free
    p_unlock_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == OFS_UNLOCK |=> st_q.fsm == FS_IDLE && !st_q.locked);

    // R9: the error state always reports failure
    p_err_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fsm == FS_ERR |-> st_q.code == CS_FAIL);

    // R8: idle never coexists with a held lock
    p_idle_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fsm == FS_IDLE |-> !st_q.locked);

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eng_busy,
    output logic              eng_avail,
    output logic [31:0]       eng_word,
    input  logic              eng_pop,
    output logic [31:0]       eng_cmd,
    output logic [31:0]       eng_len,
    input  logic              eng_post,
    input  logic              eng_fail,
    input  logic [31:0]       eng_rsp
);

    logic          buf_we;
    logic [IW-1:0] buf_widx, buf_ridx;

    mbx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .buf_we    (buf_we),
        .buf_widx  (buf_widx),
        .buf_ridx  (buf_ridx),
        .eng_busy  (eng_busy),
        .eng_avail (eng_avail),
        .eng_pop   (eng_pop),
        .eng_cmd   (eng_cmd),
        .eng_len   (eng_len),
        .eng_post  (eng_post),
        .eng_fail  (eng_fail),
        .eng_rsp   (eng_rsp)
    );

    mbx_buf #(.DEPTH(DEPTH), .DW(32)) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_idx  (buf_widx),
        .wr_data (bus_wdata),
        .rd_idx  (buf_ridx),
        .rd_data (eng_word)
    );

endmodule

// File: tb/sim_cmd_mailbox.sv
`timescale 1ns/1ps
module sim_cmd_mailbox;

    localparam int CYC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_busy, eng_avail;
    logic [31:0] eng_word, eng_cmd, eng_len;
    logic        eng_pop = 1'b0, eng_post = 1'b0, eng_fail = 1'b0;
    logic [31:0] eng_rsp = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CYC/2) clk = ~clk;

    cmd_mailbox u0 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_avail(eng_avail), .eng_word(eng_word),
        .eng_pop(eng_pop), .eng_cmd(eng_cmd), .eng_len(eng_len),
        .eng_post(eng_post), .eng_fail(eng_fail), .eng_rsp(eng_rsp)
    );

    // status value: lock flag at bit 9, state at [8:6], code at [3:0]
    function automatic logic [31:0] stv(input bit lk, input int fs, input int cs);
        return (32'(lk) << 9) | (32'(fs) << 6) | 32'(cs);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each read cycle
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) chk("scoreboard-empty", 32'd1, 32'd0);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic pop();
        @(posedge clk); #1; eng_pop = 1'b1;
        @(posedge clk); #1; eng_pop = 1'b0;
    endtask

    task automatic post(input bit f, input logic [31:0] r);
        @(posedge clk); #1; eng_post = 1'b1; eng_fail = f; eng_rsp = r;
        @(posedge clk); #1; eng_post = 1'b0; eng_fail = 1'b0;
    endtask

    initial begin
        #(CYC * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        rd(6'h1C, 32'h0, "R1 reset status");
        chk("R1 eng_busy at reset", 32'(eng_busy), 32'd0);

        wr(6'h08, 32'hDEAD_0000);
        wr(6'h18, 32'h1);
        rd(6'h08, 32'h0, "R14 cmd ignored while free");
        rd(6'h1C, 32'h0, "R14 status unchanged while free");

        rd(6'h00, 32'h0, "R2 first lock read");
        rd(6'h00, 32'h1, "R2 second lock read");
        rd(6'h1C, stv(1, 1, 0), "R2 R3 status after grant");

        wr(6'h08, 32'hC0DE_0001);
        rd(6'h1C, stv(1, 2, 0), "R4 status after command");
        rd(6'h08, 32'hC0DE_0001, "R4 command readback");
        wr(6'h0C, 32'd10);
        rd(6'h1C, stv(1, 3, 0), "R4 status after length");
        chk("R4 eng_cmd", eng_cmd, 32'hC0DE_0001);
        chk("R4 eng_len", eng_len, 32'd10);

        wr(6'h10, 32'hAAAA_0001);
        wr(6'h10, 32'hBBBB_0002);
        wr(6'h10, 32'hCCCC_0003);
        wr(6'h18, 32'h1);
        rd(6'h1C, stv(1, 4, 0), "R6 status executing");
        chk("R6 eng_busy", 32'(eng_busy), 32'd1);
        chk("R5 word 0", eng_word, 32'hAAAA_0001);
        pop();
        chk("R5 word 1", eng_word, 32'hBBBB_0002);
        pop();
        chk("R5 word 2", eng_word, 32'hCCCC_0003);
        chk("R5 avail before last pop", 32'(eng_avail), 32'd1);
        pop();
        chk("R5 avail after last pop", 32'(eng_avail), 32'd0);
        rd(6'h1C, stv(1, 4, 0), "R6 still busy after pops");

        post(1'b0, 32'h0000_1234);
        rd(6'h1C, stv(1, 5, 2), "R7 status complete");
        rd(6'h14, 32'h0000_1234, "R7 response word");
        wr(6'h18, 32'h0);
        rd(6'h1C, 32'h0, "R8 status after release");
        rd(6'h00, 32'h0, "R8 lock free again");

        wr(6'h0C, 32'd4);
        rd(6'h1C, stv(1, 6, 3), "R9 length before command");
        wr(6'h18, 32'h0);
        rd(6'h1C, 32'h0, "R8 release from error");

        rd(6'h00, 32'h0, "R10 lock");
        wr(6'h08, 32'h1);
        wr(6'h0C, 32'd8);
        wr(6'h10, 32'h1);
        wr(6'h10, 32'h2);
        rd(6'h1C, stv(1, 3, 0), "R10 full payload no error");
        wr(6'h10, 32'h3);
        rd(6'h1C, stv(1, 6, 3), "R10 extra word");
        wr(6'h20, 32'h0);
        rd(6'h1C, 32'h0, "R13 unlock from error");

        rd(6'h00, 32'h0, "R11 lock");
        wr(6'h08, 32'h1);
        wr(6'h0C, 32'd8);
        wr(6'h10, 32'h1);
        wr(6'h18, 32'h1);
        rd(6'h1C, stv(1, 6, 3), "R11 early execute");
        wr(6'h20, 32'h0);

        rd(6'h00, 32'h0, "R12 lock");
        wr(6'h08, 32'h1);
        wr(6'h0C, 32'd256);
        rd(6'h1C, stv(1, 3, 0), "R12 length at capacity");
        wr(6'h20, 32'h0);
        rd(6'h1C, 32'h0, "R13 unlock from data stage");
        rd(6'h00, 32'h0, "R12 lock again");
        wr(6'h08, 32'h1);
        wr(6'h0C, 32'd257);
        rd(6'h1C, stv(1, 6, 3), "R12 length over capacity");
        wr(6'h20, 32'h0);

        rd(6'h00, 32'h0, "R7 lock fail path");
        wr(6'h08, 32'h2);
        wr(6'h0C, 32'd0);
        wr(6'h18, 32'h1);
        chk("R5 no words for zero length", 32'(eng_avail), 32'd0);
        post(1'b1, 32'h0000_0005);
        rd(6'h1C, stv(1, 5, 3), "R7 status failure");
        rd(6'h14, 32'h0000_0005, "R7 failure response");
        wr(6'h18, 32'h0);

        rd(6'h00, 32'h0, "R13 lock");
        wr(6'h08, 32'h3);
        wr(6'h0C, 32'd0);
        wr(6'h18, 32'h1);
        wr(6'h20, 32'h0);
        rd(6'h1C, 32'h0, "R13 unlock while engine busy");
        chk("R13 eng_busy cleared", 32'(eng_busy), 32'd0);
        rd(6'h00, 32'h0, "R13 lock free after abort");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule